// File: doc/BRIEF.md
# Descriptor-Chain DMA Channel Sequencer

This block is the control engine of one DMA channel. Memory holds a linked list of 16-byte command descriptors. The engine reads the descriptor at its command pointer and decodes the command. It then carries out one of these actions: a device transfer in either direction, a single-word load or store, a no-op, or a stop. Once the action finishes, the engine writes the descriptor back with a residual count and a snapshot of the channel status. It then decides whether to interrupt and whether to branch. While the run level and the active flag are both high it moves straight on to the next descriptor, with no help from outside.

Software starts a chain by pulsing `start` with a pointer. It can then gate the chain with `run`, and it can steer the wait, interrupt and branch tests through three mask/value selectors that are compared against the device status lines. Word 0 of a descriptor holds the request count in bits [15:0] and the command in bits [31:16]. Word 1 is the data address, word 2 the branch or dependent address, and word 3 holds the residual in [15:0] and the transfer status in [31:16].

Top module: `dchain_seq`

## Requirements
- R1: After reset, `mem_req`, `xfer_req` and `irq` are low, `cmd_ptr` is 0, and the active and dead status bits are clear.
- R2: A `start` pulse with active clear loads `cmd_ptr` with `start_ptr` with bits [3:0] forced to 0. It also sets active and clears dead and BT. A `start` pulse while active is set is ignored. A descriptor fetch (four word reads at `cmd_ptr`+0, +4, +8, +12) begins only while `run` and active are both high.
- R3: The command opcode is in bits [15:12]: 0 output-more, 1 output-last, 2 input-more, 3 input-last, 4 load-word, 5 store-word, 6 no-op, 7 stop. For opcodes 0..3 the engine holds `xfer_req` with `xfer_out` = 1 for opcodes 0 and 1, `xfer_last` = 1 for opcodes 1 and 3, `xfer_addr` = word 1 and `xfer_len` = request count, until `xfer_done`.
- R4: The residual written to word 3 bits [15:0] is the request count minus `xfer_count`, or 0 if `xfer_count` is larger. It is 0 for every command that is not a transfer.
- R5: On completion the engine writes the whole descriptor to `cmd_ptr`, words 0 to 3 in order. Word 3 carries the status word in [31:16] and the residual in [15:0].
- R6: The status word has run in bit 15, flush in bit 13, wake in bit 12, dead in bit 11, active in bit 10, BT in bit 8 and `dev_stat` in bits [3:0]. All other bits are 0.
- R7: The interrupt mode is in command bits [5:4]. A selector has its mask in bits [7:4] and its value in [3:0], and it matches when `dev_stat` equals the value on every masked bit. The modes are 0 never, 1 on match, 2 on no match, 3 always. A hit gives a one-cycle `irq` after writeback.
- R8: The branch mode is in bits [3:2], with the same encoding and using `br_sel`. A taken branch loads `cmd_ptr` from word 2 with bits [3:0] cleared and sets BT. Otherwise `cmd_ptr` advances by 16 and BT clears.
- R9: Load-word reads the word at word 1 (aligned to 4) into word 2 before writeback. Store-word writes word 2 to that address. Neither one ever branches.
- R10: Stop clears active and performs no writeback. An opcode above 7 or a nonzero key (bits [10:8]) sets dead, clears active, pulses `irq` and performs no writeback.
- R11: The wait mode is in bits [1:0] and uses `wait_sel`. While it evaluates true after the action, no writeback, pointer change or bus request takes place.
- R12: `wake_in` sets wake and each descriptor fetch clears it. `flush_in` sets flush, and flush clears in the cycle after a descriptor's writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run level; chain advances only while high |
| start | input | 1 | Load pointer and set active (when inactive) |
| start_ptr | input | ADDR_W | First descriptor address |
| wake_in | input | 1 | Sets the wake status bit |
| flush_in | input | 1 | Sets the flush status bit |
| dev_stat | input | DEV_W | Device status lines for conditions |
| intr_sel | input | 2*DEV_W | Interrupt mask/value selector |
| br_sel | input | 2*DEV_W | Branch mask/value selector |
| wait_sel | input | 2*DEV_W | Wait mask/value selector |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| xfer_req | output | 1 | Device transfer request, held until `xfer_done` |
| xfer_out | output | 1 | 1 = memory to device |
| xfer_last | output | 1 | End-of-packet marker |
| xfer_addr | output | ADDR_W | Transfer buffer address |
| xfer_len | output | 16 | Requested byte count |
| xfer_done | input | 1 | Transfer finished |
| xfer_count | input | 16 | Bytes actually moved |
| cmd_ptr | output | ADDR_W | Current command pointer |
| status | output | 16 | Channel status word |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Most internal faults reach the memory port within one descriptor. A wrong opcode decode or a bad residual computation shows up in the word-3 data of the next writeback. A fault in the pointer or BT update shows up at the address of the very next fetch, and in `cmd_ptr` one cycle after the final writeback. A wait test that releases too early produces a write burst while the bench still holds the condition true. A lost flush or wake bit changes the status half of the written word. For these reasons the bench compares every bus write, every device request, the interrupt count and the final pointer and status against its own walk of the chain.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
   localparam int WORD_W     = 32;
   localparam int DESC_WORDS = 4;
   localparam int DESC_BYTES = 16;
   localparam int CNT_W      = 16;
   localparam int CMD_W      = 16;
   localparam int STAT_W     = 16;

   // opcode values (command bits [15:12])
   localparam logic [3:0] OP_OUT_MORE = 4'd0;
   localparam logic [3:0] OP_OUT_LAST = 4'd1;
   localparam logic [3:0] OP_IN_MORE  = 4'd2;
   localparam logic [3:0] OP_IN_LAST  = 4'd3;
   localparam logic [3:0] OP_LOAD     = 4'd4;
   localparam logic [3:0] OP_STORE    = 4'd5;
   localparam logic [3:0] OP_NOP      = 4'd6;
   localparam logic [3:0] OP_STOP     = 4'd7;

   // condition modes
   localparam logic [1:0] CM_NEVER   = 2'd0;
   localparam logic [1:0] CM_MATCH   = 2'd1;
   localparam logic [1:0] CM_NOMATCH = 2'd2;
   localparam logic [1:0] CM_ALWAYS  = 2'd3;

   // status bit positions
   localparam int SB_RUN    = 15;
   localparam int SB_FLUSH  = 13;
   localparam int SB_WAKE   = 12;
   localparam int SB_DEAD   = 11;
   localparam int SB_ACTIVE = 10;
   localparam int SB_BT     = 8;

   typedef enum logic [3:0] {
      S_IDLE, S_FETCH, S_DECODE, S_XFER, S_LDRD, S_STWR, S_WAIT, S_WB, S_FIN
   } seq_state_e;
endpackage

// File: rtl/dchain_cond.sv
module dchain_cond #(
   parameter int DEV_W = 4
) (
   input  logic [1:0]         mode,
   input  logic [DEV_W-1:0]   dev,
   input  logic [2*DEV_W-1:0] sel,
   output logic               hit
);
   import dchain_pkg::*;

   logic match;

   always_comb begin
      match = (((dev ^ sel[DEV_W-1:0]) & sel[2*DEV_W-1:DEV_W]) == '0);
      unique case (mode)
         CM_NEVER:   hit = 1'b0;
         CM_MATCH:   hit = match;
         CM_NOMATCH: hit = !match;
         default:    hit = 1'b1;
      endcase
   end
endmodule

// File: rtl/dchain_decode.sv
module dchain_decode
   import dchain_pkg::*;
(
   input  logic [CMD_W-1:0] cmd,
   output logic             bad,
   output logic             is_stop,
   output logic             is_xfer,
   output logic             is_load,
   output logic             is_store,
   output logic             x_out,
   output logic             x_last,
   output logic             may_branch,
   output logic [1:0]       m_intr,
   output logic [1:0]       m_br,
   output logic [1:0]       m_wait
);
   logic [3:0] op;
   logic [2:0] key;

   always_comb begin
      op         = cmd[15:12];
      key        = cmd[10:8];
      bad        = (op > OP_STOP) || (key != 3'd0);
      is_stop    = (op == OP_STOP);
      is_xfer    = (op <= OP_IN_LAST);
      is_load    = (op == OP_LOAD);
      is_store   = (op == OP_STORE);
      x_out      = (op == OP_OUT_MORE) || (op == OP_OUT_LAST);
      x_last     = (op == OP_OUT_LAST) || (op == OP_IN_LAST);
      may_branch = !is_load && !is_store;
      m_intr     = cmd[5:4];
      m_br       = cmd[3:2];
      m_wait     = cmd[1:0];
   end
endmodule

// File: rtl/dchain_seq.sv
module dchain_seq
   import dchain_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DEV_W  = 4,
   parameter int WB_ALL = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 start,
   input  logic [ADDR_W-1:0]    start_ptr,
   input  logic                 wake_in,
   input  logic                 flush_in,
   input  logic [DEV_W-1:0]     dev_stat,
   input  logic [2*DEV_W-1:0]   intr_sel,
   input  logic [2*DEV_W-1:0]   br_sel,
   input  logic [2*DEV_W-1:0]   wait_sel,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [WORD_W-1:0]    mem_wdata,
   input  logic                 mem_ack,
   input  logic [WORD_W-1:0]    mem_rdata,
   output logic                 xfer_req,
   output logic                 xfer_out,
   output logic                 xfer_last,
   output logic [ADDR_W-1:0]    xfer_addr,
   output logic [CNT_W-1:0]     xfer_len,
   input  logic                 xfer_done,
   input  logic [CNT_W-1:0]     xfer_count,
   output logic [ADDR_W-1:0]    cmd_ptr,
   output logic [STAT_W-1:0]    status,
   output logic                 irq
);
   localparam int SEL_W = 2 * DEV_W;
   localparam int IDX_W = $clog2(DESC_WORDS);
   localparam logic [IDX_W-1:0] WB_FIRST = (WB_ALL != 0) ? IDX_W'(0) : IDX_W'(2);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

   if (ADDR_W < 5 || ADDR_W > WORD_W) begin : g_bad_addr_w
      $error("dchain_seq: ADDR_W out of range");
   end
   if (DEV_W < 1 || DEV_W > SB_BT) begin : g_bad_dev_w
      $error("dchain_seq: DEV_W out of range");
   end

   seq_state_e                         state_q;
   logic [DESC_WORDS-1:0][WORD_W-1:0]  dw_q;
   logic [IDX_W-1:0]                   idx_q;
   logic [ADDR_W-1:0]                  ptr_q;
   logic [CNT_W-1:0]                   res_q;
   logic active_q, dead_q, bt_q, wake_q, flush_q, irq_q;

   // decode of the held command
   logic d_bad, d_stop, d_xfer, d_load, d_store, d_out, d_last, d_brok;
   logic [1:0] m_intr, m_br, m_wait;

   dchain_decode u_dec (
      .cmd        (dw_q[0][WORD_W-1:CNT_W]),
      .bad        (d_bad),
      .is_stop    (d_stop),
      .is_xfer    (d_xfer),
      .is_load    (d_load),
      .is_store   (d_store),
      .x_out      (d_out),
      .x_last     (d_last),
      .may_branch (d_brok),
      .m_intr     (m_intr),
      .m_br       (m_br),
      .m_wait     (m_wait)
   );

   // condition evaluators: 0 interrupt, 1 branch, 2 wait
   logic [1:0]       c_mode [3];
   logic [SEL_W-1:0] c_sel  [3];
   logic [2:0]       c_hit;

   always_comb begin
      c_mode[0] = m_intr;  c_sel[0] = intr_sel;
      c_mode[1] = m_br;    c_sel[1] = br_sel;
      c_mode[2] = m_wait;  c_sel[2] = wait_sel;
   end

   for (genvar gi = 0; gi < 3; gi++) begin : g_cond
      dchain_cond #(.DEV_W(DEV_W)) u_cond (
         .mode (c_mode[gi]),
         .dev  (dev_stat),
         .sel  (c_sel[gi]),
         .hit  (c_hit[gi])
      );
   end

   logic intr_hit, br_hit, wait_hit;
   assign intr_hit = c_hit[0];
   assign br_hit   = c_hit[1];
   assign wait_hit = c_hit[2];

   // status word
   logic [STAT_W-1:0] status_w;
   always_comb begin
      status_w                 = '0;
      status_w[SB_RUN]         = run;
      status_w[SB_FLUSH]       = flush_q;
      status_w[SB_WAKE]        = wake_q;
      status_w[SB_DEAD]        = dead_q;
      status_w[SB_ACTIVE]      = active_q;
      status_w[SB_BT]          = bt_q;
      status_w[DEV_W-1:0]      = dev_stat;
   end

   logic [CNT_W-1:0]  req_cnt;
   logic [ADDR_W-1:0] data_addr, word_addr, br_target;
   assign req_cnt   = dw_q[0][CNT_W-1:0];
   assign data_addr = dw_q[1][ADDR_W-1:0];
   assign word_addr = {dw_q[1][ADDR_W-1:2], 2'b00};
   assign br_target = {dw_q[2][ADDR_W-1:4], 4'b0000};

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         dw_q     <= '0;
         idx_q    <= '0;
         ptr_q    <= '0;
         res_q    <= '0;
         active_q <= 1'b0;
         dead_q   <= 1'b0;
         bt_q     <= 1'b0;
         wake_q   <= 1'b0;
         flush_q  <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (wake_in)  wake_q  <= 1'b1;
         if (flush_in) flush_q <= 1'b1;
         if (start && !active_q) begin
            ptr_q    <= {start_ptr[ADDR_W-1:4], 4'b0000};
            active_q <= 1'b1;
            dead_q   <= 1'b0;
            bt_q     <= 1'b0;
         end
         unique case (state_q)
            S_IDLE: begin
               if (run && active_q) begin
                  state_q <= S_FETCH;
                  idx_q   <= '0;
                  wake_q  <= 1'b0;
               end
            end
            S_FETCH: begin
               if (mem_ack) begin
                  dw_q[idx_q] <= mem_rdata;
                  if (idx_q == IDX_LAST) begin
                     state_q <= S_DECODE;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            S_DECODE: begin
               res_q <= '0;
               if (d_bad) begin
                  dead_q   <= 1'b1;
                  active_q <= 1'b0;
                  irq_q    <= 1'b1;
                  state_q  <= S_IDLE;
               end else if (d_stop) begin
                  active_q <= 1'b0;
                  state_q  <= S_IDLE;
               end else if (d_xfer) begin
                  state_q <= S_XFER;
               end else if (d_load) begin
                  state_q <= S_LDRD;
               end else if (d_store) begin
                  state_q <= S_STWR;
               end else begin
                  state_q <= S_WAIT;
               end
            end
            S_XFER: begin
               if (xfer_done) begin
                  res_q   <= (xfer_count >= req_cnt) ? '0 : (req_cnt - xfer_count);
                  state_q <= S_WAIT;
               end
            end
            S_LDRD: begin
               if (mem_ack) begin
                  dw_q[2] <= mem_rdata;
                  state_q <= S_WAIT;
               end
            end
            S_STWR: begin
               if (mem_ack) state_q <= S_WAIT;
            end
            S_WAIT: begin
               if (!wait_hit) begin
                  dw_q[3] <= {status_w, res_q};
                  idx_q   <= WB_FIRST;
                  state_q <= S_WB;
               end
            end
            S_WB: begin
               if (mem_ack) begin
                  if (idx_q == IDX_LAST) begin
                     state_q <= S_FIN;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            S_FIN: begin
               flush_q <= 1'b0;
               irq_q   <= intr_hit;
               if (d_brok && br_hit) begin
                  ptr_q <= br_target;
                  bt_q  <= 1'b1;
               end else begin
                  ptr_q <= ptr_q + ADDR_W'(DESC_BYTES);
                  bt_q  <= 1'b0;
               end
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // memory port
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = ptr_q + ADDR_W'({idx_q, 2'b00});
      mem_wdata = dw_q[idx_q];
      unique case (state_q)
         S_FETCH: mem_req = 1'b1;
         S_LDRD: begin
            mem_req  = 1'b1;
            mem_addr = word_addr;
         end
         S_STWR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = word_addr;
            mem_wdata = dw_q[2];
         end
         S_WB: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
         end
         default: ;
      endcase
   end

   assign xfer_req  = (state_q == S_XFER);
   assign xfer_out  = d_out;
   assign xfer_last = d_last;
   assign xfer_addr = data_addr;
   assign xfer_len  = req_cnt;
   assign cmd_ptr   = ptr_q;
   assign status    = status_w;
   assign irq       = irq_q;

   // checks
   p_bus_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && xfer_req));
   p_xfer_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && !xfer_done |=> xfer_req && $stable(xfer_addr) && $stable(xfer_len));
   p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                             && $stable(mem_wdata));
   p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   p_kill_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dead_q) |-> irq);
   p_wait_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WAIT) |-> !mem_req && !xfer_req);
   p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      active_q && start && (state_q != S_FIN) |=> (ptr_q == $past(ptr_q)));
endmodule

// File: tb/dchain_seq_tb.sv
module dchain_seq_tb;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, run, start, wake_in, flush_in;
   logic [31:0] start_ptr;
   logic [3:0]  dev_stat;
   logic [7:0]  intr_sel, br_sel, wait_sel;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        xfer_req, xfer_out, xfer_last, xfer_done;
   logic [31:0] xfer_addr;
   logic [15:0] xfer_len, xfer_count;
   logic [31:0] cmd_ptr;
   logic [15:0] status;
   logic        irq;

   dchain_seq u_dut (
      .clk(clk), .rst_n(rst_n), .run(run), .start(start), .start_ptr(start_ptr),
      .wake_in(wake_in), .flush_in(flush_in), .dev_stat(dev_stat),
      .intr_sel(intr_sel), .br_sel(br_sel), .wait_sel(wait_sel),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .xfer_req(xfer_req), .xfer_out(xfer_out), .xfer_last(xfer_last),
      .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_done(xfer_done),
      .xfer_count(xfer_count), .cmd_ptr(cmd_ptr), .status(status), .irq(irq)
   );

   int n_vec = 0;
   int n_bad = 0;

   logic [31:0] mem [logic [31:0]];
   logic [31:0] mm  [logic [31:0]];

   typedef struct { logic [31:0] a; logic [31:0] d; } wr_t;
   typedef struct { logic o; logic l; logic [31:0] a; logic [15:0] n; } xf_t;
   wr_t exp_wr[$];
   xf_t exp_xf[$];

   int          cap = 65535;
   int          irq_seen = 0;
   int          irq_exp = 0;
   int          dcnt = 0;
   logic [31:0] ptr_exp;
   logic [15:0] st_exp;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rdm(logic [31:0] a);
      return mm.exists(a) ? mm[a] : 32'h0;
   endfunction

   function automatic bit cnd(logic [1:0] c, logic [3:0] d, logic [7:0] s);
      bit m;
      m = (((d ^ s[3:0]) & s[7:4]) == 4'h0);
      case (c)
         2'd0: return 1'b0;
         2'd1: return m;
         2'd2: return !m;
         default: return 1'b1;
      endcase
   endfunction

   function automatic logic [31:0] w0f(int op, int key, int ic, int bc, int wc, int req);
      return {op[3:0], 1'b0, key[2:0], 2'b00, ic[1:0], bc[1:0], wc[1:0], req[15:0]};
   endfunction

   task automatic put(logic [31:0] a, logic [31:0] w0, logic [31:0] w1, logic [31:0] w2);
      mem[a] = w0; mem[a+4] = w1; mem[a+8] = w2; mem[a+12] = 32'h0;
      mm[a]  = w0; mm[a+4]  = w1; mm[a+8]  = w2; mm[a+12]  = 32'h0;
   endtask

   // behavioural walk of a chain: expected writes, transfers, pointer, status
   task automatic model(logic [31:0] p0, logic [3:0] dv, bit flush1);
      logic [31:0] p, w0, w1, w2, w3;
      logic [15:0] req, res, st;
      logic [3:0]  op;
      bit bt, dead, act, first;
      int moved;
      xf_t x;
      wr_t w;
      p = p0; bt = 0; dead = 0; act = 1; first = 1;
      for (int k = 0; k < 64; k++) begin
         w0 = rdm(p); w1 = rdm(p+4); w2 = rdm(p+8);
         op = w0[31:28]; req = w0[15:0];
         if (op > 4'd7 || w0[26:24] != 3'd0) begin
            dead = 1; act = 0; irq_exp++; break;
         end
         if (op == 4'd7) begin act = 0; break; end
         res = 16'h0;
         if (op < 4'd4) begin
            x.o = (op < 4'd2); x.l = op[0]; x.a = w1; x.n = req;
            exp_xf.push_back(x);
            moved = (int'(req) > cap) ? cap : int'(req);
            res = req - 16'(moved);
         end
         if (op == 4'd4) w2 = rdm({w1[31:2], 2'b00});
         if (op == 4'd5) begin
            w.a = {w1[31:2], 2'b00}; w.d = w2;
            exp_wr.push_back(w); mm[w.a] = w2;
         end
         st = 16'h0; st[15] = 1'b1; st[13] = flush1 && first; st[10] = 1'b1;
         st[8] = bt; st[3:0] = dv;
         w3 = {st, res};
         w.a = p;    w.d = w0; exp_wr.push_back(w);
         w.a = p+4;  w.d = w1; exp_wr.push_back(w);
         w.a = p+8;  w.d = w2; exp_wr.push_back(w);
         w.a = p+12; w.d = w3; exp_wr.push_back(w);
         mm[p+8] = w2; mm[p+12] = w3;
         if (cnd(w0[21:20], dv, intr_sel)) irq_exp++;
         if (op != 4'd4 && op != 4'd5 && cnd(w0[19:18], dv, br_sel)) begin
            p = {w2[31:4], 4'h0}; bt = 1;
         end else begin
            p = p + 32'd16; bt = 0;
         end
         first = 0;
      end
      ptr_exp = p;
      st_exp = 16'h0; st_exp[15] = 1'b1; st_exp[11] = dead; st_exp[10] = act;
      st_exp[8] = bt; st_exp[3:0] = dv;
   endtask

   // memory responder and write comparator
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (rst_n && mem_req) begin
         mem_ack = 1'b1;
         if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            if (exp_wr.size() == 0) begin
               n_vec++; n_bad++;
               $display("FAIL R5 write with none expected actual=%h:%h expected=none",
                        mem_addr, mem_wdata);
            end else begin
               wr_t w;
               w = exp_wr.pop_front();
               chk("R5 writeback address", mem_addr, w.a);
               chk("R4 R5 R6 writeback data", mem_wdata, w.d);
            end
         end else begin
            mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
         end
      end
   end

   // device responder and handshake comparator
   always @(negedge clk) begin
      if (xfer_done) begin
         xfer_done = 1'b0;
      end else if (rst_n && xfer_req) begin
         dcnt++;
         if (dcnt == 3) begin
            dcnt = 0;
            xfer_done = 1'b1;
            xfer_count = (int'(xfer_len) > cap) ? 16'(cap) : xfer_len;
            if (exp_xf.size() == 0) begin
               n_vec++; n_bad++;
               $display("FAIL R3 transfer with none expected actual=%h expected=none",
                        xfer_addr);
            end else begin
               xf_t x;
               x = exp_xf.pop_front();
               chk("R3 transfer request", {xfer_out, xfer_last, xfer_addr, xfer_len},
                   {x.o, x.l, x.a, x.n});
            end
         end
      end
   end

   always @(negedge clk) if (rst_n && irq) irq_seen++;

   task automatic launch(logic [31:0] p);
      start_ptr = p; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic finish_chain(string tag);
      int t;
      t = 0;
      while (status[10] && t < 5000) begin @(negedge clk); t++; end
      repeat (4) @(negedge clk);
      chk({tag, " R8 final pointer"}, cmd_ptr, ptr_exp);
      chk({tag, " R6 R10 final status"}, status, st_exp);
      chk({tag, " R7 interrupt count"}, irq_seen, irq_exp);
      chk({tag, " R5 writes outstanding"}, exp_wr.size(), 0);
      chk({tag, " R3 transfers outstanding"}, exp_xf.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; run = 1'b0; start = 1'b0; wake_in = 1'b0; flush_in = 1'b0;
      start_ptr = '0; dev_stat = 4'h5; intr_sel = 8'h00; br_sel = 8'h00; wait_sel = 8'h00;
      mem_ack = 1'b0; mem_rdata = '0; xfer_done = 1'b0; xfer_count = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset outputs", {mem_req, xfer_req, irq, status[11:10]}, 5'b0);
      chk("R1 reset pointer", cmd_ptr, 32'h0);

      // transfers of every kind, residuals, sequential advance
      cap = 100;
      put(32'h100, w0f(0, 0, 0, 0, 0, 64),  32'h1000, 32'h0);
      put(32'h110, w0f(1, 0, 0, 0, 0, 200), 32'h2000, 32'h0);
      put(32'h120, w0f(2, 0, 0, 0, 0, 8),   32'h2100, 32'h0);
      put(32'h130, w0f(3, 0, 0, 0, 0, 300), 32'h2200, 32'h0);
      put(32'h140, w0f(6, 0, 0, 0, 0, 0),   32'h0,    32'h500);
      put(32'h150, w0f(7, 0, 0, 0, 0, 0),   32'h0,    32'h0);
      model(32'h100, 4'h5, 1'b0);
      run = 1'b1;
      launch(32'h10B);
      finish_chain("xfer chain");

      // interrupts, branches, load and store
      cap = 65535;
      intr_sel = 8'hF5; br_sel = 8'hF5;
      mem[32'h3000] = 32'hCAFE0001; mm[32'h3000] = 32'hCAFE0001;
      put(32'h400, w0f(6, 0, 3, 3, 0, 0), 32'h0,    32'h80B);
      put(32'h800, w0f(4, 0, 1, 3, 0, 4), 32'h3002, 32'h0);
      put(32'h810, w0f(5, 0, 2, 3, 0, 4), 32'h3104, 32'h12345678);
      put(32'h820, w0f(6, 0, 0, 2, 0, 0), 32'h0,    32'hA00);
      put(32'h830, w0f(6, 0, 0, 1, 0, 0), 32'h0,    32'h900);
      put(32'h900, w0f(7, 0, 0, 0, 0, 0), 32'h0,    32'h0);
      model(32'h400, 4'h5, 1'b0);
      launch(32'h400);
      finish_chain("branch chain");
      chk("R9 store landed in memory", mem[32'h3104], 32'h12345678);

      // kill by bad opcode, then by nonzero key
      put(32'hA00, w0f(6, 0, 0, 0, 0, 0), 32'h0, 32'h0);
      put(32'hA10, w0f(9, 0, 0, 0, 0, 0), 32'h0, 32'h0);
      model(32'hA00, 4'h5, 1'b0);
      launch(32'hA00);
      finish_chain("bad opcode");
      chk("R10 dead after bad opcode", status[11], 1'b1);
      put(32'hB00, w0f(0, 3, 0, 0, 0, 16), 32'h4000, 32'h0);
      model(32'hB00, 4'h5, 1'b0);
      launch(32'hB00);
      finish_chain("bad key");
      chk("R10 dead after bad key", status[11], 1'b1);

      // run gating, wake, wait hold, start ignored, flush
      run = 1'b0;
      wait_sel = 8'hF5; intr_sel = 8'h00; br_sel = 8'h00;
      @(negedge clk); wake_in = 1'b1; @(negedge clk); wake_in = 1'b0;
      chk("R12 wake set by input", status[12], 1'b1);
      put(32'hC00, w0f(6, 0, 0, 0, 1, 0), 32'h0, 32'h0);
      put(32'hC10, w0f(7, 0, 0, 0, 0, 0), 32'h0, 32'h0);
      model(32'hC00, 4'h6, 1'b1);
      launch(32'hC00);
      repeat (10) @(negedge clk);
      chk("R2 no fetch while run low", {mem_req, status[10]}, 2'b01);
      run = 1'b1;
      repeat (30) @(negedge clk);
      chk("R11 no writeback while waiting", exp_wr.size(), 4);
      chk("R11 pointer held while waiting", cmd_ptr, 32'hC00);
      chk("R12 wake cleared by fetch", status[12], 1'b0);
      flush_in = 1'b1; @(negedge clk); flush_in = 1'b0;
      launch(32'hF00);
      chk("R2 start ignored while active", cmd_ptr, 32'hC00);
      dev_stat = 4'h6;
      finish_chain("wait chain");
      chk("R12 flush cleared after writeback", status[13], 1'b0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule